// File: doc/BRIEF.md
# Pipelined Integer Lifting Wavelet Transform

This block computes a single-level forward integer wavelet transform on a stream of 10-bit samples. Each accepted input cycle carries one pair of samples, an odd sample (the one to be predicted) and an even sample. Each accepted pair also yields one approximation coefficient and one detail coefficient. Five cascaded three-term arithmetic cores each carry out one lifting step. Each core forms `x + (ci*y >>> 3) + (cj*z >>> 3)` with 6-bit signed coefficients taken from an eight-entry register bank.

Every step needs a neighbouring value from the pair before or the pair after. Delay registers supply these terms, and two hold stages make the path through the chain seven registers long. Until enough real pairs have entered, the output carries warm-up results, and the valid flag stays low for those. The chain moves only on cycles that accept a pair, so the gaps in the input stream need no handling. The coefficients are loaded through a small write port while no samples are flowing.

Top module: `lift_dwt`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid`, `out_approx` and `out_detail` are 0 and all eight coefficients are 0. With no coefficient writes after reset, the block therefore passes samples through: approximation[i] equals even[i] and detail[i] equals odd[i].
- R2: A write with `cfg_we`=1 and `cfg_addr`=k (k from 0 to 7) loads `cfg_data` into coefficient C(k+1) at that clock edge. The new value is used by every pair accepted in the cycle that follows or later. Coefficients that are not addressed keep their values.
- R3: Each core term is the full signed product of coefficient and data, shifted right arithmetically by 3 and kept to its low 10 bits. The three terms are summed modulo 2^10 and read as two's complement. Full-scale samples of ±511 and coefficients of -32 and 31 wrap in this way.
- R4: With odd input o[i] and even input e[i], the block computes g1[i]=o[i]+T(C1,e[i]); f1[i]=e[i]+T(C2,g1[i])+T(C3,g1[i+1]); g2[i]=g1[i]+T(C4,f1[i])+T(C5,f1[i-1]); a[i]=f1[i]+T(C6,g2[i])+T(C7,g2[i-1]); d[i]=g2[i]+T(C8,a[i+1]). Here T is the term of R3, and the pairs before the first one after reset count as zero.
- R5: Accepting pair number n (counting from 0 after reset) sets `out_valid` for exactly the next cycle when n ≥ 6. In that cycle `out_approx` and `out_detail` show a[n-6] and d[n-6]. This is a latency of seven accepted pairs.
- R6: The first six accepted pairs after reset never set `out_valid`. The outputs still show the zero-padded results a[n-6] and d[n-6] for those pairs.
- R7: A cycle with `in_valid`=0 does not advance the chain. In the next cycle `out_valid` is 0 and `out_approx` and `out_detail` keep their previous values.
- R8: A reset in the middle of a stream discards all history. The next stream gives exactly the results of R4 to R6, as if no earlier pairs had entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The sample pair is accepted this cycle |
| in_odd | input | 10 | Odd sample o[i] (signed) |
| in_even | input | 10 | Even sample e[i] (signed) |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 3 | Coefficient index; k selects C(k+1) |
| cfg_data | input | 6 | Signed coefficient value |
| out_valid | output | 1 | The result pair is valid this cycle |
| out_approx | output | 10 | Approximation coefficient (signed) |
| out_detail | output | 10 | Detail coefficient (signed) |

## Verification
The bench builds the block at its package defaults: 10-bit data, 6-bit coefficients, a shift of 3 and eight coefficients, which gives the fixed fill depth of six pairs. At these widths the 10-bit range is small enough that random samples near ±511 combined with coefficients of -32 and 31 reach the wrap rule of R3 in nearly every pair. The zero-padded warm-up results of R6 can be compared value for value, not only masked. Gapped input exercises the stall behaviour of R7 at every pipeline depth. A reset in mid-stream shows whether any delay register keeps a stale neighbour value.

// File: rtl/lift_pkg.sv
package lift_pkg;
    localparam int DW     = 10;
    localparam int CW     = 6;
    localparam int SHIFT  = 3;
    localparam int NSTEP  = 5;
    localparam int NHOLD  = 2;
    localparam int NCOEF  = 8;
    localparam int AW     = $clog2(NCOEF);
    localparam int LAT    = NSTEP + NHOLD;

    typedef logic signed [DW-1:0] smp_t;
    typedef logic signed [CW-1:0] coef_t;

    // Register set of the lifting chain; index comments are relative to
    // the advance count t after the register has been written.
    typedef struct packed {
        smp_t r1_g1;   // g1[t]
        smp_t r1_f0;   // e[t]
        smp_t d1_g1;   // g1[t-1]
        smp_t d1_f0;   // e[t-1]
        smp_t r2_f1;   // f1[t-2]
        smp_t r2_g1;   // g1[t-2]
        smp_t p2_f1;   // f1[t-3]
        smp_t r3_g2;   // g2[t-3]
        smp_t r3_f1;   // f1[t-3]
        smp_t p3_g2;   // g2[t-4]
        smp_t r4_a;    // a[t-4]
        smp_t r4_g2;   // g2[t-4]
        smp_t d4_a;    // a[t-5]
        smp_t d4_g2;   // g2[t-5]
        smp_t r5_a;    // a[t-6]
        smp_t r5_d;    // d[t-6]
    } chain_t;
endpackage

// File: rtl/lift_core.sv
module lift_core #(
    parameter int DW    = 10,
    parameter int CW    = 6,
    parameter int SHIFT = 3
) (
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] y,
    input  logic signed [DW-1:0] z,
    input  logic signed [CW-1:0] ci,
    input  logic signed [CW-1:0] cj,
    output logic signed [DW-1:0] w
);
    localparam int PW = DW + CW;

    logic signed [PW-1:0] prod_y;
    logic signed [PW-1:0] prod_z;
    logic signed [DW-1:0] term_y;
    logic signed [DW-1:0] term_z;

    always_comb begin
        prod_y = PW'(ci) * PW'(y);
        prod_z = PW'(cj) * PW'(z);
        term_y = DW'(prod_y >>> SHIFT);
        term_z = DW'(prod_z >>> SHIFT);
        w      = x + term_y + term_z;
    end
endmodule

// File: rtl/lift_coef_bank.sv
module lift_coef_bank #(
    parameter int N  = 8,
    parameter int CW = 6,
    parameter int AW = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic signed [CW-1:0] data,
    output logic signed [CW-1:0] coef [N]
);
    logic signed [CW-1:0] coef_d [N];
    logic signed [CW-1:0] coef_q [N];

    always_comb begin
        coef_d = coef_q;
        if (we && (int'(addr) < N)) begin
            coef_d[addr] = data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) coef_q[k] <= '0;
        end else begin
            coef_q <= coef_d;
        end
    end

    assign coef = coef_q;

    for (genvar k = 0; k < N; k++) begin : g_chk
        // R2: an addressed write lands in its own entry
        assert_coef_load_R2: assert property (@(posedge clk) disable iff (rst)
            (we && int'(addr) == k) |=> (coef_q[k] == $past(data)));
        // R2: entries not addressed keep their value
        assert_coef_keep_R2: assert property (@(posedge clk) disable iff (rst)
            !(we && int'(addr) == k) |=> $stable(coef_q[k]));
    end
endmodule

// File: rtl/lift_fill_ctl.sv
module lift_fill_ctl #(
    parameter int LAT = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic valid
);
    localparam int FILL = LAT - 1;
    localparam int CNTW = $clog2(LAT);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            vld;
    } fill_t;

    fill_t fill_d, fill_q;

    always_comb begin
        fill_d     = fill_q;
        fill_d.vld = 1'b0;
        if (adv) begin
            if (fill_q.cnt == CNTW'(FILL)) begin
                fill_d.vld = 1'b1;
            end else begin
                fill_d.cnt = fill_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fill_q <= '0;
        else     fill_q <= fill_d;
    end

    assign valid = fill_q.vld;

    // R6: the counter never runs beyond the fill depth
    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (rst)
        fill_q.cnt <= CNTW'(FILL));
endmodule

// File: rtl/lift_dwt.sv
module lift_dwt
    import lift_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_odd,
    input  logic signed [DW-1:0] in_even,
    input  logic                 cfg_we,
    input  logic [AW-1:0]        cfg_addr,
    input  logic signed [CW-1:0] cfg_data,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_approx,
    output logic signed [DW-1:0] out_detail
);
    coef_t coef [NCOEF];

    lift_coef_bank #(.N(NCOEF), .CW(CW), .AW(AW)) u_coef (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .addr (cfg_addr),
        .data (cfg_data),
        .coef (coef)
    );

    lift_fill_ctl #(.LAT(LAT)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .adv   (in_valid),
        .valid (out_valid)
    );

    smp_t  cx  [NSTEP];
    smp_t  cy  [NSTEP];
    smp_t  cz  [NSTEP];
    smp_t  cw  [NSTEP];
    coef_t cci [NSTEP];
    coef_t ccj [NSTEP];

    for (genvar s = 0; s < NSTEP; s++) begin : g_step
        lift_core #(.DW(DW), .CW(CW), .SHIFT(SHIFT)) u_core (
            .x  (cx[s]),
            .y  (cy[s]),
            .z  (cz[s]),
            .ci (cci[s]),
            .cj (ccj[s]),
            .w  (cw[s])
        );
    end

    chain_t chain_d, chain_q;

    // operand routing: step s takes its neighbours from the delay registers
    always_comb begin
        cx[0] = in_odd;        cy[0] = in_even;       cz[0] = '0;
        cci[0] = coef[0];      ccj[0] = '0;
        cx[1] = chain_q.d1_f0; cy[1] = chain_q.d1_g1; cz[1] = chain_q.r1_g1;
        cci[1] = coef[1];      ccj[1] = coef[2];
        cx[2] = chain_q.r2_g1; cy[2] = chain_q.r2_f1; cz[2] = chain_q.p2_f1;
        cci[2] = coef[3];      ccj[2] = coef[4];
        cx[3] = chain_q.r3_f1; cy[3] = chain_q.r3_g2; cz[3] = chain_q.p3_g2;
        cci[3] = coef[5];      ccj[3] = coef[6];
        cx[4] = chain_q.d4_g2; cy[4] = chain_q.r4_a;  cz[4] = '0;
        cci[4] = coef[7];      ccj[4] = '0;
    end

    always_comb begin
        chain_d = chain_q;
        if (in_valid) begin
            chain_d.r1_g1 = cw[0];
            chain_d.r1_f0 = in_even;
            chain_d.d1_g1 = chain_q.r1_g1;
            chain_d.d1_f0 = chain_q.r1_f0;
            chain_d.r2_f1 = cw[1];
            chain_d.r2_g1 = chain_q.d1_g1;
            chain_d.p2_f1 = chain_q.r2_f1;
            chain_d.r3_g2 = cw[2];
            chain_d.r3_f1 = chain_q.r2_f1;
            chain_d.p3_g2 = chain_q.r3_g2;
            chain_d.r4_a  = cw[3];
            chain_d.r4_g2 = chain_q.r3_g2;
            chain_d.d4_a  = chain_q.r4_a;
            chain_d.d4_g2 = chain_q.r4_g2;
            chain_d.r5_a  = chain_q.d4_a;
            chain_d.r5_d  = cw[4];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign out_approx = chain_q.r5_a;
    assign out_detail = chain_q.r5_d;

    // R7: an idle input cycle freezes the results and withholds valid
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_approx) && $stable(out_detail) && !out_valid));
    // R5: a valid result always follows an accepted pair
    assert_valid_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
endmodule

// File: tb/sim_lift_dwt.sv
module sim_lift_dwt;
    localparam int CLK_P = 10;
    localparam int DW    = 10;
    localparam int CW    = 6;
    localparam int OFF   = 8;
    localparam int NMAX  = 64;
    localparam int SZ    = NMAX + OFF + 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_odd = '0;
    logic signed [DW-1:0] in_even = '0;
    logic                 cfg_we = 1'b0;
    logic [2:0]           cfg_addr = '0;
    logic signed [CW-1:0] cfg_data = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_approx;
    logic signed [DW-1:0] out_detail;

    lift_dwt u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_odd(in_odd), .in_even(in_even),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .out_valid(out_valid), .out_approx(out_approx), .out_detail(out_detail)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit chk_en = 0;
    string run_tag = "R4";

    int cv [1:8];
    int o_in [SZ];
    int e_in [SZ];
    int g1 [SZ];
    int f1 [SZ];
    int g2 [SZ];
    int aa [SZ];
    int dd [SZ];

    int n_acc = 0;
    bit exp_v = 0;
    bit exp_adv = 0;
    int exp_a = 0;
    int exp_d = 0;
    int seed = 32'h1234_5678;

    function automatic int wrap(int v);
        int m;
        m = v & ((1 << DW) - 1);
        return (m >= (1 << (DW - 1))) ? m - (1 << DW) : m;
    endfunction

    function automatic int term(int c, int y);
        return wrap((c * y) >>> 3);
    endfunction

    function automatic int at(ref int arr [SZ], input int j);
        return (j >= 0 && j < SZ) ? arr[j] : 0;
    endfunction

    function automatic int rnd(int lo, int hi);
        seed = seed * 1103515245 + 12345;
        return lo + int'((seed >>> 8) & 32'h7fff_ffff) % (hi - lo + 1);
    endfunction

    // behavioural model of the zero-padded lifting equations (R4)
    task automatic build_model();
        for (int j = 0; j < SZ; j++) g1[j] = wrap(o_in[j] + term(cv[1], e_in[j]));
        for (int j = 0; j < SZ; j++)
            f1[j] = wrap(e_in[j] + term(cv[2], g1[j]) + term(cv[3], at(g1, j + 1)));
        for (int j = 0; j < SZ; j++)
            g2[j] = wrap(g1[j] + term(cv[4], f1[j]) + term(cv[5], at(f1, j - 1)));
        for (int j = 0; j < SZ; j++)
            aa[j] = wrap(f1[j] + term(cv[6], g2[j]) + term(cv[7], at(g2, j - 1)));
        for (int j = 0; j < SZ; j++)
            dd[j] = wrap(g2[j] + term(cv[8], at(aa, j + 1)));
    endtask

    // expected port values, advanced on every accepted pair
    always @(posedge clk) begin
        if (rst) begin
            n_acc <= 0; exp_v <= 0; exp_adv <= 0; exp_a <= 0; exp_d <= 0;
        end else if (in_valid) begin
            exp_v   <= (n_acc >= 6);
            exp_adv <= 1;
            exp_a   <= aa[n_acc - 6 + OFF];
            exp_d   <= dd[n_acc - 6 + OFF];
            n_acc   <= n_acc + 1;
        end else begin
            exp_v   <= 0;
            exp_adv <= 0;
        end
    end

    task automatic check(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && chk_en) begin
            check((n_acc <= 6) ? "R6 valid" : "R5 valid", int'(out_valid), int'(exp_v));
            check(exp_adv ? {run_tag, " approx"} : "R7 approx hold", int'(out_approx), exp_a);
            check(exp_adv ? {run_tag, " detail"} : "R7 detail hold", int'(out_detail), exp_d);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_valid = 0; cfg_we = 0;
        repeat (2) @(negedge clk);
        rst = 0;
        for (int k = 1; k <= 8; k++) cv[k] = 0;
    endtask

    task automatic write_coefs(int c1, int c2, int c3, int c4, int c5, int c6, int c7, int c8);
        int vals [8];
        vals = '{c1, c2, c3, c4, c5, c6, c7, c8};
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cfg_we = 1; cfg_addr = 3'(k); cfg_data = CW'(vals[k]);
            cv[k + 1] = vals[k];
        end
        @(negedge clk);
        cfg_we = 0;
    endtask

    // mode 0 ramp, 1 random, 2 full-scale extremes
    task automatic fill_data(int n, int mode);
        for (int j = 0; j < SZ; j++) begin
            o_in[j] = 0; e_in[j] = 0;
        end
        for (int i = 0; i < n; i++) begin
            if (mode == 0) begin
                o_in[OFF + i] = 7 * i - 60; e_in[OFF + i] = 300 - 13 * i;
            end else if (mode == 1) begin
                o_in[OFF + i] = rnd(-400, 400); e_in[OFF + i] = rnd(-400, 400);
            end else begin
                o_in[OFF + i] = rnd(0, 1) ? 511 : -511;
                e_in[OFF + i] = rnd(0, 1) ? 511 : -512;
            end
        end
        build_model();
    endtask

    task automatic stream(int n_send, bit gaps);
        chk_en = 1;
        for (int i = 0; i < n_send; i++) begin
            if (gaps) begin
                int idle;
                idle = rnd(0, 2);
                for (int q = 0; q < idle; q++) begin
                    @(negedge clk);
                    in_valid = 0;
                end
            end
            @(negedge clk);
            in_valid = 1;
            in_odd  = DW'(o_in[OFF + i]);
            in_even = DW'(e_in[OFF + i]);
        end
        @(negedge clk);
        in_valid = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R5 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 1; k <= 8; k++) cv[k] = 0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 approx in reset", int'(out_approx), 0);
        check("R1 detail in reset", int'(out_detail), 0);
        rst = 0;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 approx after reset", int'(out_approx), 0);
        check("R1 detail after reset", int'(out_detail), 0);

        // R1: cleared coefficients give a pass-through
        run_tag = "R1";
        fill_data(20, 0);
        stream(20, 0);

        // R2: coefficients loaded just before the stream are used at once
        do_reset();
        write_coefs(-8, 2, 3, -4, -5, 6, 7, -9);
        run_tag = "R2";
        fill_data(40, 1);
        stream(40, 0);

        // R7: gapped input, R4 values
        run_tag = "R4";
        fill_data(50, 1);
        do_reset();
        write_coefs(-12, 4, 4, -3, -2, 5, 1, -7);
        build_model();
        stream(50, 1);

        // R3: full-scale data with extreme coefficients
        do_reset();
        write_coefs(-32, 31, -32, 31, 31, -32, 31, -32);
        run_tag = "R3";
        fill_data(40, 2);
        stream(40, 0);

        // R8: reset part-way through a stream, then a fresh stream
        do_reset();
        write_coefs(9, -6, 11, -13, 3, 2, -1, 15);
        run_tag = "R4";
        fill_data(30, 1);
        stream(15, 0);
        do_reset();
        write_coefs(-9, 6, -11, 13, -3, -2, 1, -15);
        run_tag = "R8";
        fill_data(30, 1);
        stream(30, 1);

        chk_en = 0;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule